// File: doc/BRIEF.md
# Quad-Span Telephony Card Register File

This block is the byte-wide register file that sits behind the local bus of a four-span T1 line card. It decodes an 11-bit byte address. The lower half of the address space is split into four 256-byte windows, one for each line transceiver. The block raises a chip select for the addressed transceiver and passes the low address byte through to it. When the bus reads inside a window, the block returns the transceiver's read data.

Above the windows sit the card's own registers:
- At the first of them, a write loads the timing-reference selector and a read returns interrupt status.
- The next address loads control. Control holds the interrupt enables, a test pin and the two loopback modes, and it also carries a self-clearing acknowledge bit.
- Further addresses drive the span LEDs and a second test pin.

The card interrupt pin is active low. It merges a latched local interrupt with the framer's interrupt line, and each of the two sources is gated by its own enable.

Top module: `card_regfile`

## Requirements
- R1: While bus_rd or bus_wr is high and bus_addr[10] is 0, exactly one xcvr_sel bit is high, bit bus_addr[9:8] (bit 0 = transceiver 1). At all other times xcvr_sel is 0. xcvr_addr always equals bus_addr[7:0].
- R2: A read inside a transceiver window returns xcvr_rdata on bus_rdata in the same cycle. Reads of 0x401 through 0x7FF return 0.
- R3: A write to 0x400 of a value from 0 to 4 sets sync_src to that value from the next clock edge. 0 means free run and n means span n.
- R4: A write to 0x400 of any byte value above 4 leaves sync_src unchanged.
- R5: A read of 0x400 returns {5'b0, framer_irq, int_active, int_enable}, with int_enable in bit 0.
- R6: A write to 0x401 stores the control bits as follows: bit 0 is the local interrupt enable, bit 1 drives test1, bit 2 is the framer interrupt enable, bit 5 drives rmt_loop and bit 6 drives loc_loop.
- R7: A write to 0x401 with bit 7 set clears the latched interrupt-active flag. If irq_event is high in the same cycle, the flag is set instead. Bit 7 is not stored.
- R8: A high irq_event at a clock edge sets the interrupt-active flag. The flag stays set until it is acknowledged.
- R9: irq_n is low exactly when (local enable AND interrupt active) OR (framer enable AND framer_irq) is true.
- R10: A write to 0x402 loads leds. Bit 2k is the green LED and bit 2k+1 is the red LED of span k+1.
- R11: A write to 0x403 sets test2 to data bit 0.
- R12: After reset, every register is 0 and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data |
| xcvr_sel | output | 4 | Transceiver chip selects, active high |
| xcvr_addr | output | 8 | Transceiver register address |
| xcvr_rdata | input | 8 | Read data from the selected transceiver |
| irq_event | input | 1 | Local interrupt event |
| framer_irq | input | 1 | Framer interrupt, active high |
| irq_n | output | 1 | Card interrupt, active low |
| sync_src | output | 3 | Timing reference select |
| test1 | output | 1 | Test pin 1 |
| test2 | output | 1 | Test pin 2 |
| leds | output | 8 | Span LED drives |
| rmt_loop | output | 1 | Remote serial loopback enable |
| loc_loop | output | 1 | Local loopback enable |

## Verification
The assertions check these properties on every cycle:
- No more than one chip select is high at a time.
- The sync selector never holds a value above 4, and a write of an out-of-range value leaves it unchanged.
- An event sets the interrupt flag.
- An acknowledge with no event clears the flag.

The bench scenarios cover what a single-cycle property cannot show: the bit layout of status, control and LEDs, the read-data path from the windows, the zero reads of unused addresses, and the combined active-low interrupt pin as enables, events, acknowledges and the framer line interleave over long random sequences.

// File: rtl/card_regfile.sv
module card_regfile #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int NSPAN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [NSPAN-1:0] xcvr_sel,
  output logic [7:0]    xcvr_addr,
  input  logic [DW-1:0] xcvr_rdata,
  input  logic          irq_event,
  input  logic          framer_irq,
  output logic          irq_n,
  output logic [2:0]    sync_src,
  output logic          test1,
  output logic          test2,
  output logic [2*NSPAN-1:0] leds,
  output logic          rmt_loop,
  output logic          loc_loop
);
  logic in_win, in_loc;
  logic wr_sync, wr_ctl, wr_led, wr_t2, ack;
  logic int_en, fint_en, int_act;

  assign in_win = ~bus_addr[AW-1];
  assign in_loc = bus_addr[AW-1] && (bus_addr[AW-2:2] == '0);
  assign xcvr_addr = bus_addr[7:0];
  assign xcvr_sel = ((bus_rd | bus_wr) && in_win) ? NSPAN'(1) << bus_addr[9:8] : '0;

  assign wr_sync = bus_wr && in_loc && bus_addr[1:0] == 2'd0;
  assign wr_ctl  = bus_wr && in_loc && bus_addr[1:0] == 2'd1;
  assign wr_led  = bus_wr && in_loc && bus_addr[1:0] == 2'd2;
  assign wr_t2   = bus_wr && in_loc && bus_addr[1:0] == 2'd3;
  assign ack     = wr_ctl && bus_wdata[7];

  always_comb begin
    bus_rdata = '0;
    if (in_win)
      bus_rdata = xcvr_rdata;
    else if (in_loc && bus_addr[1:0] == 2'd0)
      bus_rdata = {5'b0, framer_irq, int_act, int_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_src <= '0;
      int_en   <= 1'b0;
      fint_en  <= 1'b0;
      test1    <= 1'b0;
      test2    <= 1'b0;
      rmt_loop <= 1'b0;
      loc_loop <= 1'b0;
      leds     <= '0;
      int_act  <= 1'b0;
    end else begin
      if (wr_sync && bus_wdata <= DW'(NSPAN))
        sync_src <= bus_wdata[2:0];
      if (wr_ctl) begin
        int_en   <= bus_wdata[0];
        test1    <= bus_wdata[1];
        fint_en  <= bus_wdata[2];
        rmt_loop <= bus_wdata[5];
        loc_loop <= bus_wdata[6];
      end
      if (wr_led) leds <= bus_wdata;
      if (wr_t2) test2 <= bus_wdata[0];
      if (irq_event) int_act <= 1'b1;
      else if (ack) int_act <= 1'b0;
    end
  end

  assign irq_n = ~((int_en & int_act) | (fint_en & framer_irq));

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xcvr_sel));
  // R3
  sync_range_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_src <= 3'd4);
  // R4
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sync && bus_wdata > 8'd4) |=> $stable(sync_src));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_event) |=> !int_act);
  // R8
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_event |=> int_act);
endmodule

// File: tb/test_card_regfile.sv
module test_card_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [10:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, xcvr_rdata = '0;
  logic bus_wr = 0, bus_rd = 0, irq_event = 0, framer_irq = 0;
  logic [7:0] bus_rdata, xcvr_addr, leds;
  logic [3:0] xcvr_sel;
  logic irq_n, test1, test2, rmt_loop, loc_loop;
  logic [2:0] sync_src;

  int n_run = 0, n_fail = 0;
  logic [2:0] m_sync = 0;
  logic m_en = 0, m_fen = 0, m_t1 = 0, m_t2 = 0, m_rl = 0, m_ll = 0, m_act = 0;
  logic [7:0] m_led = 0;

  card_regfile i_card_regfile (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq_n();
    return ~((m_en & m_act) | (m_fen & framer_irq));
  endfunction

  task automatic cycle(input logic w, input logic [10:0] a, input logic [7:0] d, input logic ev);
    bus_wr = w; bus_addr = a; bus_wdata = d; irq_event = ev;
    @(posedge clk);
    if (w && a == 11'h400 && d <= 8'd4) m_sync = d[2:0];
    if (w && a == 11'h401) begin
      m_en = d[0]; m_t1 = d[1]; m_fen = d[2]; m_rl = d[5]; m_ll = d[6];
    end
    if (w && a == 11'h402) m_led = d;
    if (w && a == 11'h403) m_t2 = d[0];
    if (ev) m_act = 1;
    else if (w && a == 11'h401 && d[7]) m_act = 0;
    @(negedge clk);
    bus_wr = 0; irq_event = 0;
  endtask

  task automatic check_all();
    check("R3/R4 sync_src", sync_src, m_sync);
    check("R6 test1", test1, m_t1);
    check("R6 rmt_loop", rmt_loop, m_rl);
    check("R6 loc_loop", loc_loop, m_ll);
    check("R10 leds", leds, m_led);
    check("R11 test2", test2, m_t2);
    check("R9 irq_n", irq_n, exp_irq_n());
    bus_rd = 1; bus_addr = 11'h400; #1;
    check("R5 status", bus_rdata, {5'b0, framer_irq, m_act, m_en});
    check("R1 no select on local read", xcvr_sel, 0);
    bus_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R12
    check("R12 reset sync", sync_src, 0);
    check("R12 reset leds", leds, 0);
    check("R12 reset irq_n", irq_n, 1);
    check("R12 reset loops", {rmt_loop, loc_loop, test1, test2}, 0);
    rst_n = 1;
    @(negedge clk);
    check_all();

    // R1 R2: window decode and read-back
    for (int n = 0; n < 4; n++) begin
      logic [7:0] lo = 8'($urandom), rd = 8'($urandom);
      bus_rd = 1; bus_addr = {1'b0, 2'(n), lo}; xcvr_rdata = rd; #1;
      check("R1 xcvr_sel", xcvr_sel, 1 << n);
      check("R1 xcvr_addr", xcvr_addr, lo);
      check("R2 window read", bus_rdata, rd);
      bus_rd = 0; #1;
      check("R1 idle select", xcvr_sel, 0);
    end
    for (int k = 0; k < 20; k++) begin
      bus_rd = 1;
      bus_addr = (k == 0) ? 11'h401 : (k == 1) ? 11'h7FF : 11'h404 + 11'($urandom_range(0, 11'h3FB));
      #1;
      check("R2 unused read zero", bus_rdata, 0);
      check("R1 no select unused", xcvr_sel, 0);
      bus_rd = 0;
    end

    // R3 R4 boundaries
    cycle(1, 11'h400, 8'd4, 0); check("R3 sync=4", sync_src, 4);
    cycle(1, 11'h400, 8'd5, 0); check("R4 sync ignores 5", sync_src, 4);
    cycle(1, 11'h400, 8'hFF, 0); check("R4 sync ignores FF", sync_src, 4);
    cycle(1, 11'h400, 8'd0, 0); check("R3 sync=0", sync_src, 0);

    // R7 R8: event priority over acknowledge
    cycle(1, 11'h401, 8'h01, 0);
    cycle(0, 11'h000, 8'h00, 1);
    check("R8 event sets, irq_n low", irq_n, 0);
    cycle(1, 11'h401, 8'h81, 1);
    check("R7 event beats ack", irq_n, 0);
    cycle(1, 11'h401, 8'h81, 0);
    check("R7 ack clears", irq_n, 1);
    check_all();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      framer_irq = 1'($urandom);
      if (op < 6)
        cycle(1, 11'h400 + 11'($urandom_range(0, 3)), 8'($urandom), 1'($urandom_range(0, 3) == 0));
      else if (op < 8)
        cycle(0, 11'($urandom), 8'($urandom), 1);
      else
        cycle(0, 11'h500, 8'($urandom), 0);
      check_all();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule